// File: doc/BRIEF.md
# Burst Read Address Sequencer

This block produces the word address for each beat of a synchronous burst read from a memory of 2M words. It starts in asynchronous read mode. An active clock edge that sees the address-valid strobe low moves it into synchronous mode and captures a start address. After a configurable number of initial wait clocks, it steps the address once per clock and raises `ready` for every beat that carries a valid word.

Three burst kinds are supported. Wrap mode circles inside the aligned group of 8, 16 or 32 words that holds the start address. Fixed mode delivers exactly 8, 16 or 32 consecutive words with no group limit, then stops and flags the end. Continuous mode counts upward without limit and rolls over at the top of the address space. In fixed and continuous bursts whose start address is not 8-word aligned, the first crossing of a 32-word boundary inserts a short latency, during which `ready` is low. Array access and the data path belong to the surrounding logic.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low the block is asynchronous: `sync_mode`, `ready` and `burst_end` are 0 and `addr` is 0.
- R2: At any clock edge with `ce_n` high the block returns to asynchronous mode (`sync_mode`, `ready`, `burst_end` all 0), whatever `adv_n` is.
- R3: At a clock edge with `ce_n` low and `adv_n` low, `sync_mode` becomes 1 and `addr` takes `start_addr`. This restarts any burst in progress.
- R4: After the capturing edge, `ready` stays low for `wait_cfg` clocks with `addr` held at the start address, then rises. With `wait_cfg` = 0 it is high right after the capturing edge.
- R5: Mode code 01 is wrap. The address steps by one per ready beat inside its aligned group and returns from the top of the group to its base; for example a group of 8 from 11h gives 11h..17h, 10h, 11h and so on.
- R6: Mode code 10 is fixed length. Exactly the selected number of consecutive words is delivered, each with `ready` high. On the following edge `ready` drops, `burst_end` rises and `addr` holds the last word until a new capture or the enable goes high.
- R7: Mode codes 00 and 11 are continuous. The address steps by one per ready beat and rolls over from all ones to zero.
- R8: In fixed or continuous mode with start bits [2:0] not all zero, the first step onto an address whose bits [4:0] are zero makes `ready` low for `BOUND_LAT` clocks, with `addr` already showing that boundary address. This happens once per burst. It never happens in wrap mode or with an aligned start.
- R9: Length code 00 selects 8 words, 01 selects 16, and 10 or 11 select 32. Mode, length and wait inputs are sampled only at the capturing edge; changing them during a burst has no effect on `addr` or `ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge is active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Enable, active low; high forces asynchronous mode |
| adv_n | input | 1 | Address-valid strobe, active low |
| start_addr | input | ADDR_W | Start word address captured with the strobe |
| mode | input | 2 | Burst kind: 00/11 continuous, 01 wrap, 10 fixed |
| len_sel | input | 2 | Group or length: 00 = 8, 01 = 16, 10/11 = 32 words |
| wait_cfg | input | WAIT_W | Initial wait clocks before the first word |
| sync_mode | output | 1 | High while in synchronous read mode |
| addr | output | ADDR_W | Current burst word address |
| ready | output | 1 | High when `addr` carries a valid beat |
| burst_end | output | 1 | High after a fixed-length burst has finished |

## Verification
A wrong state or a stale counter inside the sequencer shows up at the ports on the very next clock. It appears as an address that did not step, that stepped outside its wrap group, or that skipped the rollover, or as `ready` high or low one beat too early or too late. A latency that is missing or repeated moves every later address by whole clocks, so a comparison on each cycle catches it at the boundary beat itself. A miscounted fixed length shows as `burst_end` rising one clock off.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

   typedef enum logic [1:0] {
      MODE_CONT     = 2'b00,
      MODE_WRAP     = 2'b01,
      MODE_FIXED    = 2'b10,
      MODE_CONT_ALT = 2'b11
   } burst_mode_e;

   typedef enum logic [2:0] {
      S_ASYNC,
      S_INIT,
      S_RUN,
      S_LAT,
      S_DONE
   } seq_state_e;

   localparam int CNT_W = 6;

   function automatic logic [CNT_W-1:0] len_words(input logic [1:0] sel);
      case (sel)
         2'b00:   len_words = CNT_W'(8);
         2'b01:   len_words = CNT_W'(16);
         default: len_words = CNT_W'(32);
      endcase
   endfunction

endpackage

// File: rtl/burst_next_addr.sv
module burst_next_addr
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W = 21
) (
   input  logic [ADDR_W-1:0] cur,
   input  logic [1:0]        mode,
   input  logic [1:0]        len_sel,
   output logic [ADDR_W-1:0] nxt,
   output logic              at_bound
);
   localparam int N_GRP = 3;

   logic [ADDR_W-1:0] wrap_c [N_GRP];
   logic [ADDR_W-1:0] lin;

   // one wrap candidate per group size: 8, 16, 32 words
   for (genvar g = 0; g < N_GRP; g++) begin : g_wrap
      localparam int K = 3 + g;
      always_comb begin
         wrap_c[g] = cur;
         wrap_c[g][K-1:0] = cur[K-1:0] + K'(1);
      end
   end

   assign lin      = cur + ADDR_W'(1);
   assign at_bound = (lin[4:0] == 5'd0);

   always_comb begin
      if (burst_mode_e'(mode) == MODE_WRAP) begin
         case (len_sel)
            2'b00:   nxt = wrap_c[0];
            2'b01:   nxt = wrap_c[1];
            default: nxt = wrap_c[2];
         endcase
      end else begin
         nxt = lin;
      end
   end

endmodule

// File: rtl/burst_tick_counter.sv
module burst_tick_counter #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         last
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (load)             cnt <= load_val;
      else if (dec && cnt != 0)  cnt <= cnt - W'(1);
   end

   assign last = (cnt == W'(1));

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W    = 21,
   parameter int WAIT_W    = 4,
   parameter int BOUND_LAT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              adv_n,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [1:0]        mode,
   input  logic [1:0]        len_sel,
   input  logic [WAIT_W-1:0] wait_cfg,
   output logic              sync_mode,
   output logic [ADDR_W-1:0] addr,
   output logic              ready,
   output logic              burst_end
);
   localparam int LAT_BITS = $clog2(BOUND_LAT + 1);
   localparam int TMR_W    = (WAIT_W > LAT_BITS) ? WAIT_W : ((LAT_BITS > 0) ? LAT_BITS : 1);
   localparam bit LAT_EN   = (BOUND_LAT > 0);

   if (ADDR_W < 6) begin : g_chk_aw
      $error("ADDR_W must be at least 6");
   end
   if (WAIT_W < 1) begin : g_chk_ww
      $error("WAIT_W must be at least 1");
   end
   if (BOUND_LAT < 0) begin : g_chk_lat
      $error("BOUND_LAT must not be negative");
   end

   seq_state_e        state;
   logic [1:0]        mode_q;
   logic [1:0]        len_q;
   logic [CNT_W-1:0]  beats;
   logic              lat_arm;
   logic [ADDR_W-1:0] nxt;
   logic              at_bound;
   logic              capture;
   logic              run_step;
   logic              fixed_done;
   logic              go_lat;
   logic              tmr_load;
   logic              tmr_dec;
   logic              tmr_last;
   logic [TMR_W-1:0]  tmr_val;
   logic              start_unaligned;

   burst_next_addr #(.ADDR_W(ADDR_W)) u_next (
      .cur      (addr),
      .mode     (mode_q),
      .len_sel  (len_q),
      .nxt      (nxt),
      .at_bound (at_bound)
   );

   assign capture    = !ce_n && !adv_n;
   assign run_step   = !ce_n && adv_n && (state == S_RUN);
   assign fixed_done = (burst_mode_e'(mode_q) == MODE_FIXED) &&
                       (CNT_W'(beats + CNT_W'(1)) == len_words(len_q));
   assign start_unaligned = |start_addr[2:0];

   if (LAT_EN) begin : g_lat
      assign go_lat = lat_arm && at_bound && !fixed_done;
   end else begin : g_nolat
      assign go_lat = 1'b0;
   end

   assign tmr_load = capture || (run_step && go_lat);
   assign tmr_val  = capture ? TMR_W'(wait_cfg) : TMR_W'(BOUND_LAT);
   assign tmr_dec  = !ce_n && adv_n && (state == S_INIT || state == S_LAT);

   burst_tick_counter #(.W(TMR_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .dec      (tmr_dec),
      .last     (tmr_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_ASYNC;
         addr    <= '0;
         mode_q  <= 2'b00;
         len_q   <= 2'b00;
         beats   <= '0;
         lat_arm <= 1'b0;
      end else if (ce_n) begin
         state   <= S_ASYNC;
         lat_arm <= 1'b0;
      end else if (!adv_n) begin
         addr    <= start_addr;
         mode_q  <= mode;
         len_q   <= len_sel;
         beats   <= '0;
         lat_arm <= LAT_EN && (burst_mode_e'(mode) != MODE_WRAP) && start_unaligned;
         state   <= (wait_cfg == '0) ? S_RUN : S_INIT;
      end else begin
         case (state)
            S_INIT, S_LAT: begin
               if (tmr_last) state <= S_RUN;
            end
            S_RUN: begin
               if (fixed_done) begin
                  state <= S_DONE;
               end else begin
                  addr  <= nxt;
                  beats <= beats + CNT_W'(1);
                  if (go_lat) begin
                     lat_arm <= 1'b0;
                     state   <= S_LAT;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign sync_mode = (state != S_ASYNC);
   assign ready     = (state == S_RUN);
   assign burst_end = (state == S_DONE);

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
   parameter int ADDR_W = 21
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              adv_n,
   input logic [ADDR_W-1:0] start_addr,
   input logic              sync_mode,
   input logic [ADDR_W-1:0] addr,
   input logic              ready,
   input logic              burst_end
);
   p_ce_async_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |=> (!sync_mode && !ready && !burst_end));

   p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !adv_n) |=> (sync_mode && addr == $past(start_addr)));

   p_ready_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> sync_mode);

   p_end_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      burst_end |-> (!ready && sync_mode));

   p_end_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_end && adv_n && !ce_n) |=> (burst_end && $stable(addr)));

   p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && adv_n && !ce_n) |=> (burst_end || addr != $past(addr)));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ce_n       (ce_n),
   .adv_n      (adv_n),
   .start_addr (start_addr),
   .sync_mode  (sync_mode),
   .addr       (addr),
   .ready      (ready),
   .burst_end  (burst_end)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
   localparam int AW  = 21;
   localparam int WW  = 4;
   localparam int LAT = 2;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n, ce_n, adv_n;
   logic [AW-1:0] start_addr;
   logic [1:0]    mode, len_sel;
   logic [WW-1:0] wait_cfg;
   logic          sync_mode, ready, burst_end;
   logic [AW-1:0] addr;

   burst_addr_seq #(.ADDR_W(AW), .WAIT_W(WW), .BOUND_LAT(LAT)) u_dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n),
      .start_addr(start_addr), .mode(mode), .len_sel(len_sel),
      .wait_cfg(wait_cfg), .sync_mode(sync_mode), .addr(addr),
      .ready(ready), .burst_end(burst_end)
   );

   int    checks = 0;
   int    failures = 0;
   string req = "R1";

   // reference model state
   bit m_sync, m_ready, m_end, m_fixed;
   int m_addr;
   bit qr[$];
   int qa[$];

   task automatic build_queue();
      int g, a, n;
      bit wrap, arm;
      g    = (len_sel == 2'b00) ? 8 : (len_sel == 2'b01) ? 16 : 32;
      wrap = (mode == 2'b01);
      m_fixed = (mode == 2'b10);
      arm  = !wrap && (int'(start_addr) % 8 != 0);
      a    = int'(start_addr);
      n    = m_fixed ? g : 150;
      qr.delete(); qa.delete();
      for (int i = 0; i < int'(wait_cfg); i++) begin
         qr.push_back(1'b0); qa.push_back(a);
      end
      for (int k = 0; k < n; k++) begin
         if (k > 0) begin
            if (wrap) a = (a - a % g) + ((a + 1) % g);
            else      a = (a + 1) % (1 << AW);
            if (arm && a % 32 == 0) begin
               for (int j = 0; j < LAT; j++) begin
                  qr.push_back(1'b0); qa.push_back(a);
               end
               arm = 1'b0;
            end
         end
         qr.push_back(1'b1); qa.push_back(a);
      end
   endtask

   task automatic model_edge();
      if (!rst_n) begin
         m_sync = 0; m_ready = 0; m_end = 0; m_addr = 0;
         qr.delete(); qa.delete();
      end else if (ce_n) begin
         m_sync = 0; m_ready = 0; m_end = 0;
         qr.delete(); qa.delete();
      end else if (!adv_n) begin
         build_queue();
         m_sync = 1; m_end = 0;
         m_ready = qr.pop_front();
         m_addr  = qa.pop_front();
      end else if (m_sync) begin
         if (qr.size() > 0) begin
            m_ready = qr.pop_front();
            m_addr  = qa.pop_front();
         end else if (m_fixed) begin
            m_ready = 0; m_end = 1;
         end
      end
   endtask

   task automatic compare();
      checks++;
      if (sync_mode !== m_sync || ready !== m_ready || burst_end !== m_end ||
          int'(addr) != m_addr) begin
         failures++;
         $display("FAIL %s t=%0t sync/ready/end/addr actual=%b/%b/%b/%h expected=%b/%b/%b/%h",
                  req, $time, sync_mode, ready, burst_end, addr,
                  m_sync, m_ready, m_end, AW'(m_addr));
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         model_edge();
         @(negedge clk);
         compare();
      end
   endtask

   task automatic capture(input int a, input logic [1:0] md, input logic [1:0] ln,
                          input int w);
      start_addr = AW'(a); mode = md; len_sel = ln; wait_cfg = WW'(w);
      adv_n = 1'b0;
      cyc(1);
      adv_n = 1'b1;
   endtask

   initial begin
      #1_000_000;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      rst_n = 0; ce_n = 1; adv_n = 1; start_addr = '0;
      mode = 2'b00; len_sel = 2'b00; wait_cfg = '0;
      @(negedge clk);
      req = "R1"; cyc(3);
      rst_n = 1; ce_n = 0;
      cyc(2);

      // wrap, group of 8 from 11h, two initial waits
      req = "R5_R4"; capture('h11, 2'b01, 2'b00, 2); cyc(20);
      req = "R5";    capture('h2D, 2'b01, 2'b01, 0); cyc(20);
      req = "R5_R9"; capture('h3E, 2'b01, 2'b11, 1); cyc(40);

      // fixed 8 from 39h: latency before 40h, then stop
      req = "R6_R8"; capture('h39, 2'b10, 2'b00, 1); cyc(15);
      req = "R6";    capture('h40, 2'b10, 2'b01, 0); cyc(22);
      req = "R6_R8"; capture('h05, 2'b10, 2'b10, 3); cyc(42);

      // continuous across rollover and a 32 boundary
      req = "R7_R8"; capture('h1FFFF5, 2'b00, 2'b00, 0); cyc(30);
      req = "R8";    capture('h23, 2'b11, 2'b00, 2); cyc(80);
      req = "R7";    capture('h100, 2'b00, 2'b01, 0); cyc(40);

      // restart mid-burst
      req = "R3"; capture('h50, 2'b00, 2'b00, 0); cyc(5);
      capture('h77, 2'b01, 2'b00, 1); cyc(12);

      // inputs changed mid-burst must be ignored
      req = "R9"; capture('h84, 2'b01, 2'b00, 0); cyc(3);
      mode = 2'b10; len_sel = 2'b10; wait_cfg = 4'd7; start_addr = 'h1234;
      cyc(20);

      // enable high returns to asynchronous mode, even with the strobe low
      req = "R2"; ce_n = 1; cyc(3);
      adv_n = 0; cyc(2); adv_n = 1;
      ce_n = 0; cyc(2);
      req = "R3"; capture('h9, 2'b10, 2'b00, 0); cyc(14);
      req = "R2"; ce_n = 1; cyc(2);
      ce_n = 0;

      req = "R1"; rst_n = 0; cyc(2); rst_n = 1; cyc(2);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule